// File: doc/BRIEF.md
# Serial-Loaded Configuration Register Bank with Deferred Update

This block is the programming front end of a fractional-N synthesizer's control logic. A three-wire serial port carries a shift clock, a data line and a latch strobe. The block samples all three in the system clock domain, shifts 32-bit words in most significant bit first, and on each latch strobe routes the word to one of five configuration registers. The three lowest bits of the word select the register.

Register 0 holds the integer and fractional divide values, and these take effect as soon as the word is written. The modulus, phase, reference counter, reference doubler, reference halver and current setting work differently. A write to their register only loads a staging copy. The staged values reach the active outputs together when register 0 is next written. Registers 3 and 4 keep their payload bits exactly as received. Each accepted write produces a one-cycle strobe together with the index of the register that was written.

Top module: `ser_cfg_bank`

## Requirements
- R1: After reset: int_o, frac_o, phase_o, dbl_o, div2_o, cur_o, r3_o, r4_o and wr_idx_o are 0; mod_o is 2; refcnt_o is 1; wr_stb_o is 0.
- R2: The shift register takes one bit of sdata_i on each rising edge of sclk_i, most significant bit first. Only the last 32 bits shifted before the latch edge are used.
- R3: On a rising edge of slatch_i, word bits [2:0] select the target register: 000 selects register 0, 001 register 1, 010 register 2, 011 register 3 and 100 register 4. The write raises wr_stb_o for exactly one cycle, with wr_idx_o equal to the code.
- R4: Codes 101, 110 and 111 change no register, staged or active, and raise no strobe.
- R5: A register 0 write updates int_o from bits [26:15] and frac_o from bits [14:3] in the strobe cycle.
- R6: A register 1 write stages the phase from bits [14:3]. phase_o keeps its value until the next register 0 write.
- R7: A register 2 write stages the modulus from bits [14:3], the reference counter from [19:15], the halver from bit 20, the doubler from bit 21 and the current setting from [25:22]. mod_o, refcnt_o, div2_o, dbl_o and cur_o keep their values until the next register 0 write.
- R8: A register 0 write moves every staged value to its output in the same cycle that int_o and frac_o update.
- R9: A write to register 3 or register 4 stores bits [31:3] of the word into r3_o or r4_o.
- R10: Staging copies reset to the same values as the active outputs. A register 0 write that comes before any register 2 write therefore leaves mod_o at 2 and refcnt_o at 1.
- R11: Outputs and wr_stb_o update on the third system clock edge after slatch_i rises, once the two synchronizer stages and the edge detector have passed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| slatch_i | input | 1 | Latch strobe, asynchronous |
| int_o | output | 12 | Active integer divide value |
| frac_o | output | 12 | Active fractional value |
| mod_o | output | 12 | Active modulus |
| phase_o | output | 12 | Active phase value |
| refcnt_o | output | 5 | Active reference counter |
| dbl_o | output | 1 | Active reference doubler enable |
| div2_o | output | 1 | Active reference halver enable |
| cur_o | output | 4 | Active current setting |
| r3_o | output | 29 | Register 3 payload |
| r4_o | output | 29 | Register 4 payload |
| wr_stb_o | output | 1 | One-cycle pulse per accepted write |
| wr_idx_o | output | 3 | Index of the last accepted register |

## Verification
The assertions assume that each high and low phase of sclk_i and slatch_i lasts at least two system clock cycles, so every edge is seen once. They also assume that sdata_i is settled before sclk_i rises and that slatch_i rises only while sclk_i is idle. The stimulus holds every level for four system cycles and changes data and strobes on the falling edge of clk_i. It is therefore well inside those limits, and no edge can be missed or counted twice.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int WORD_W   = 32;
  localparam int CTRL_W   = 3;
  localparam int FLD_W    = 12;
  localparam int REF_W    = 5;
  localparam int CUR_W    = 4;
  localparam int NREG     = 5;
  localparam int PAY_W    = WORD_W - CTRL_W;
  localparam int FLD_LSB  = CTRL_W;
  localparam int N_LSB    = FLD_LSB + FLD_W;
  localparam int REF_LSB  = FLD_LSB + FLD_W;
  localparam int DIV2_BIT = REF_LSB + REF_W;
  localparam int DBL_BIT  = DIV2_BIT + 1;
  localparam int CUR_LSB  = DBL_BIT + 1;
  localparam int SYNC_N   = 2;

  typedef enum logic [CTRL_W-1:0] {
    SEL_R0 = 3'd0,
    SEL_R1 = 3'd1,
    SEL_R2 = 3'd2,
    SEL_R3 = 3'd3,
    SEL_R4 = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [FLD_W-1:0] modv;
    logic [FLD_W-1:0] phase;
    logic [REF_W-1:0] refc;
    logic             dbl;
    logic             div2;
    logic [CUR_W-1:0] cur;
  } dbuf_t;

  localparam dbuf_t DBUF_RST = '{modv: 12'd2, phase: '0, refc: 5'd1,
                                 dbl: 1'b0, div2: 1'b0, cur: '0};
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= chain_q[STAGES-1];

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};

  assign word_o = sr_q;
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [FLD_W-1:0]  int_o,
  output logic [FLD_W-1:0]  frac_o,
  output dbuf_t             act_o,
  output logic [PAY_W-1:0]  r3_o,
  output logic [PAY_W-1:0]  r4_o,
  output logic              stb_o,
  output logic [CTRL_W-1:0] idx_o
);
  logic [CTRL_W-1:0] code;
  logic              valid;
  dbuf_t             stg_q, act_q;
  logic [FLD_W-1:0]  int_q, frac_q;
  logic [PAY_W-1:0]  r3_q, r4_q;
  logic              stb_q;
  logic [CTRL_W-1:0] idx_q;

  assign code  = word_i[CTRL_W-1:0];
  assign valid = load_i && (int'(code) < NREG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= DBUF_RST;
      act_q  <= DBUF_RST;
      int_q  <= '0;
      frac_q <= '0;
      r3_q   <= '0;
      r4_q   <= '0;
      stb_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      stb_q <= valid;
      if (valid) begin
        idx_q <= code;
        case (reg_sel_e'(code))
          SEL_R0: begin
            int_q  <= word_i[N_LSB +: FLD_W];
            frac_q <= word_i[FLD_LSB +: FLD_W];
            act_q  <= stg_q;
          end
          SEL_R1: stg_q.phase <= word_i[FLD_LSB +: FLD_W];
          SEL_R2: begin
            stg_q.modv <= word_i[FLD_LSB +: FLD_W];
            stg_q.refc <= word_i[REF_LSB +: REF_W];
            stg_q.div2 <= word_i[DIV2_BIT];
            stg_q.dbl  <= word_i[DBL_BIT];
            stg_q.cur  <= word_i[CUR_LSB +: CUR_W];
          end
          SEL_R3: r3_q <= word_i[WORD_W-1:CTRL_W];
          SEL_R4: r4_q <= word_i[WORD_W-1:CTRL_W];
          default: ;
        endcase
      end
    end
  end

  assign int_o  = int_q;
  assign frac_o = frac_q;
  assign act_o  = act_q;
  assign r3_o   = r3_q;
  assign r4_o   = r4_q;
  assign stb_o  = stb_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import sercfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              slatch_i,
  output logic [FLD_W-1:0]  int_o,
  output logic [FLD_W-1:0]  frac_o,
  output logic [FLD_W-1:0]  mod_o,
  output logic [FLD_W-1:0]  phase_o,
  output logic [REF_W-1:0]  refcnt_o,
  output logic              dbl_o,
  output logic              div2_o,
  output logic [CUR_W-1:0]  cur_o,
  output logic [PAY_W-1:0]  r3_o,
  output logic [PAY_W-1:0]  r4_o,
  output logic              wr_stb_o,
  output logic [CTRL_W-1:0] wr_idx_o
);
  localparam int NSIG = 3;
  localparam int I_DAT = 0;
  localparam int I_CLK = 1;
  localparam int I_LAT = 2;

  logic [NSIG-1:0]   lvl, rise;
  logic [WORD_W-1:0] word;
  dbuf_t             act;

  sercfg_sync #(.W(NSIG), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({slatch_i, sclk_i, sdata_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  sercfg_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(rise[I_CLK]),
    .bit_i  (lvl[I_DAT]),
    .word_o (word)
  );

  sercfg_regs u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rise[I_LAT]),
    .word_i(word),
    .int_o (int_o),
    .frac_o(frac_o),
    .act_o (act),
    .r3_o  (r3_o),
    .r4_o  (r4_o),
    .stb_o (wr_stb_o),
    .idx_o (wr_idx_o)
  );

  assign mod_o    = act.modv;
  assign phase_o  = act.phase;
  assign refcnt_o = act.refc;
  assign dbl_o    = act.dbl;
  assign div2_o   = act.div2;
  assign cur_o    = act.cur;
endmodule

// File: rtl/ser_cfg_bank_chk.sv
module ser_cfg_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_stb_o,
  input logic [2:0]  wr_idx_o,
  input logic [11:0] int_o,
  input logic [11:0] frac_o,
  input logic [11:0] mod_o,
  input logic [11:0] phase_o,
  input logic [4:0]  refcnt_o,
  input logic [3:0]  cur_o,
  input logic [28:0] r3_o
);
  assert_stb_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (wr_idx_o <= 3'd4));

  assert_quiet_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |-> ($stable(int_o) && $stable(mod_o) && $stable(phase_o) && $stable(r3_o)));

  assert_int_only_r0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && wr_idx_o != 3'd0) |-> ($stable(int_o) && $stable(frac_o)));

  assert_phase_defer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && wr_idx_o == 3'd1) |-> $stable(phase_o));

  assert_mod_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && wr_idx_o == 3'd2) |-> ($stable(mod_o) && $stable(refcnt_o) && $stable(cur_o)));
endmodule

bind ser_cfg_bank ser_cfg_bank_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_stb_o(wr_stb_o),
  .wr_idx_o(wr_idx_o),
  .int_o   (int_o),
  .frac_o  (frac_o),
  .mod_o   (mod_o),
  .phase_o (phase_o),
  .refcnt_o(refcnt_o),
  .cur_o   (cur_o),
  .r3_o    (r3_o)
);

// File: tb/sim_ser_cfg_bank.sv
`timescale 1ns/1ps
module sim_ser_cfg_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, sdata_i = 1'b0, slatch_i = 1'b0;
  logic [11:0] int_o, frac_o, mod_o, phase_o;
  logic [4:0]  refcnt_o;
  logic        dbl_o, div2_o, wr_stb_o;
  logic [3:0]  cur_o;
  logic [28:0] r3_o, r4_o;
  logic [2:0]  wr_idx_o;

  int checks = 0, failures = 0, stb_cnt = 0, cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ser_cfg_bank u0 (.*);

  always @(negedge clk_i) if (wr_stb_o) stb_cnt++;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic shift_bits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_i = bits[i];
      hold(4);
      sclk_i = 1'b1;
      hold(4);
      sclk_i = 1'b0;
    end
  endtask

  task automatic latch();
    hold(4);
    slatch_i = 1'b1;
    hold(4);
    slatch_i = 1'b0;
    hold(8);
  endtask

  task automatic send(logic [31:0] w);
    shift_bits({32'h0, w}, 32);
    latch();
  endtask

  function automatic logic [31:0] w_r0(logic [11:0] n, logic [11:0] f);
    return {5'b0, n, f, 3'b000};
  endfunction
  function automatic logic [31:0] w_r1(logic [11:0] ph);
    return {17'b0, ph, 3'b001};
  endfunction
  function automatic logic [31:0] w_r2(logic [3:0] cur, logic dbl, logic div2,
                                       logic [4:0] rc, logic [11:0] m);
    return {6'b0, cur, dbl, div2, rc, m, 3'b010};
  endfunction

  task automatic t_reset();
    chk("R1 int", int_o, 0);
    chk("R1 frac", frac_o, 0);
    chk("R1 mod", mod_o, 2);
    chk("R1 ref", refcnt_o, 1);
    chk("R1 phase", phase_o, 0);
    chk("R1 misc", {dbl_o, div2_o, cur_o}, 0);
    chk("R1 r3r4", r3_o | r4_o, 0);
    chk("R1 stb", {wr_stb_o, wr_idx_o}, 0);
  endtask

  task automatic t_first_r0();
    int s0 = stb_cnt;
    send(w_r0(12'd100, 12'd7));
    chk("R5 int", int_o, 100);
    chk("R5 frac", frac_o, 7);
    chk("R10 mod kept", mod_o, 2);
    chk("R10 ref kept", refcnt_o, 1);
    chk("R3 one strobe", stb_cnt - s0, 1);
    chk("R3 idx0", wr_idx_o, 0);
  endtask

  task automatic t_stage();
    send(w_r2(4'd9, 1'b0, 1'b1, 5'd3, 12'd1000));
    chk("R7 mod deferred", mod_o, 2);
    chk("R7 ref deferred", refcnt_o, 1);
    chk("R7 misc deferred", {dbl_o, div2_o, cur_o}, 0);
    chk("R3 idx2", wr_idx_o, 2);
    send(w_r1(12'h5A5));
    chk("R6 phase deferred", phase_o, 0);
    chk("R3 idx1", wr_idx_o, 1);
    chk("R5 int unchanged", int_o, 100);
  endtask

  task automatic t_ignored();
    int s0 = stb_cnt;
    send(32'hFFFF_FFF5);
    send(32'hFFFF_FFF6);
    send(32'hFFFF_FFFF);
    chk("R4 no strobe", stb_cnt - s0, 0);
    chk("R4 int", int_o, 100);
    chk("R4 r3", r3_o, 0);
    chk("R4 mod", mod_o, 2);
  endtask

  task automatic t_commit();
    // leading junk bits shifted out ahead of the real word
    shift_bits({24'h0, 8'hA5, w_r0(12'd200, 12'hABC)}, 40);
    latch();
    chk("R2 msb first int", int_o, 200);
    chk("R2 msb first frac", frac_o, 12'hABC);
    chk("R8 mod", mod_o, 1000);
    chk("R8 ref", refcnt_o, 3);
    chk("R8 div2", div2_o, 1);
    chk("R8 dbl", dbl_o, 0);
    chk("R8 cur", cur_o, 9);
    chk("R8 phase", phase_o, 12'h5A5);
  endtask

  task automatic t_r3_r4();
    send(32'hDEAD_BEEB);
    chk("R9 r3", r3_o, 32'hDEAD_BEEB >> 3);
    chk("R3 idx3", wr_idx_o, 3);
    send(32'h1234_567C);
    chk("R9 r4", r4_o, 32'h1234_567C >> 3);
    chk("R3 idx4", wr_idx_o, 4);
  endtask

  task automatic t_latency();
    int n = 0;
    shift_bits({32'h0, w_r0(12'd55, 12'd1)}, 32);
    hold(4);
    slatch_i = 1'b1;
    // inputs driven at negedge; wr_stb_o expected after third posedge
    while (!wr_stb_o && n < 10) begin
      @(negedge clk_i);
      n++;
    end
    chk("R11 latency", n, 3);
    chk("R11 int", int_o, 55);
    hold(4);
    slatch_i = 1'b0;
    hold(8);
  endtask

  initial begin
    hold(3);
    rst_ni = 1'b1;
    hold(3);
    t_reset();
    t_first_r0();
    t_stage();
    t_ignored();
    t_commit();
    t_r3_r4();
    t_latency();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule